// File: doc/BRIEF.md
# Shuffled Sub-DAC Test Sequence Generator

This block produces the dynamic self-test stimulus for a converter built from two sub-DACs of five bits each. While test mode is held, an up-counter walks through every code it can hold, one code per clock. Each sub-DAC receives its own permutation of the counter bits, so each one is driven through every code in a non-incremental order. A bank of per-bit 2:1 selectors sits in front of the sub-DAC inputs. With test mode high they carry the permuted test code. With test mode low they carry the normal code from the successive-approximation logic, through gates only.

The permutation for each sub-DAC is given as five 3-bit source-select fields. Field j names the counter bit that drives output bit j of that sub-DAC. The fields are captured only when a pass is started, so software may prepare the next setting while the current pass is still running. A one-cycle completion pulse marks each wrap of the counter.

The control is a two-state machine. SEQ_IDLE holds the counter at zero. Its transition "launch" is start while test mode is high, and it leads to SEQ_RUN. In SEQ_RUN the counter steps once per clock. The transition "restart" is start while test mode is high, and it clears the counter and stays in SEQ_RUN. The transition "abort" is test mode going low, and it clears the counter and returns to SEQ_IDLE.

Top module: `shuffled_dac_seq`

## Requirements
- R1: In SEQ_RUN the 5-bit count advances by one per clock, starting from 0 in the cycle after the launch edge and visiting all 32 values before repeating.
- R2: Start sampled high together with test_en clears the count to 0 at that edge, including in the middle of a pass, and captures both shuffle settings.
- R3: done is high for exactly one cycle: the cycle in which the count has just wrapped from 31 to 0. A restart taken while the count is 31 produces no done.
- R4: While test_en is low, dac_drive equals func_code combinationally, in the same cycle and without a clock edge.
- R5: While test_en is low, the count returns to 0 and start is ignored. If test_en is then raised without start, the count stays at 0, so dac_drive reads 0 for any shuffle setting and done stays low.
- R6: In test mode, dac_drive[j] equals counter bit W[s] for the lower sub-DAC, and dac_drive[5+j] equals W[s] for the upper sub-DAC. Here s is field j of that sub-DAC's captured setting, and field j occupies bits [3j+2:3j] of shuf_lo or shuf_hi. For example, fields 4,3,2,1,0 for j=0..4 give bit reversal.
- R7: A field value of 5, 6 or 7 selects counter bit W[0].
- R8: A change on shuf_hi or shuf_lo during a pass has no effect on dac_drive until the next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Test mode select; high routes test codes to the sub-DACs |
| start | input | 1 | Launches or restarts a pass when test_en is high |
| shuf_hi | input | 15 | Five 3-bit source-select fields for the upper sub-DAC |
| shuf_lo | input | 15 | Five 3-bit source-select fields for the lower sub-DAC |
| func_code | input | 10 | Functional code from the successive-approximation logic |
| dac_drive | output | 10 | Sub-DAC inputs; bits 9:5 upper, 4:0 lower |
| done | output | 1 | One-cycle pulse on each counter wrap |

## Verification
The bench builds the block with its default width of five bits per sub-DAC. This gives a 32-cycle pass that can be followed code by code, and 3-bit select fields whose values 5 to 7 fall outside the counter, so the fallback to bit 0 can be reached. An identity setting exposes the raw count at the ports, so stepping, wrap, restart and hold can be checked directly. Reversed, rotated and out-of-range settings then exercise the permutation.

// File: rtl/shuffled_dac_seq_pkg.sv
package shuffled_dac_seq_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/dts_counter.sv
module dts_counter
    import shuffled_dac_seq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic             start,
    output logic             load,
    output logic [CNT_W-1:0] cnt,
    output seq_state_t       state,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    seq_state_t state_d;

    assign load = test_en & start;

    always_comb begin
        state_d = state;
        unique case (state)
            SEQ_IDLE: if (load) state_d = SEQ_RUN;
            SEQ_RUN:  if (!test_en) state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SEQ_IDLE: cnt <= '0;
                SEQ_RUN: begin
                    if (!test_en || start) begin
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_MAX) done <= 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/dts_shuffle.sv
module dts_shuffle #(
    parameter int CNT_W = 5,
    parameter int SEL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [CNT_W*SEL_W-1:0] cfg_in,
    input  logic [CNT_W-1:0]       cnt,
    output logic [CNT_W*SEL_W-1:0] cfg_q,
    output logic [CNT_W-1:0]       code
);
    localparam int CFG_W = CNT_W * SEL_W;

    function automatic logic [CFG_W-1:0] reversed_cfg();
        logic [CFG_W-1:0] r;
        r = '0;
        for (int j = 0; j < CNT_W; j++)
            r[j*SEL_W +: SEL_W] = SEL_W'(CNT_W - 1 - j);
        return r;
    endfunction

    localparam logic [CFG_W-1:0] RST_CFG = reversed_cfg();

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cfg_q <= RST_CFG;
        else if (load) cfg_q <= cfg_in;
    end

    for (genvar j = 0; j < CNT_W; j++) begin : g_bit
        logic [SEL_W-1:0] sel;
        logic             pick;
        assign sel = cfg_q[j*SEL_W +: SEL_W];
        always_comb begin
            pick = cnt[0];
            for (int i = 0; i < CNT_W; i++)
                if (sel == SEL_W'(i)) pick = cnt[i];
        end
        assign code[j] = pick;
    end
endmodule

// File: rtl/dts_bit_mux.sv
module dts_bit_mux #(
    parameter int W = 10
) (
    input  logic         sel_test,
    input  logic [W-1:0] test_code,
    input  logic [W-1:0] func_code,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_mux
        assign dout[i] = sel_test ? test_code[i] : func_code[i];
    end
endmodule

// File: rtl/shuffled_dac_seq.sv
module shuffled_dac_seq
    import shuffled_dac_seq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 test_en,
    input  logic                                 start,
    input  logic [CNT_W*$clog2(CNT_W)-1:0]       shuf_hi,
    input  logic [CNT_W*$clog2(CNT_W)-1:0]       shuf_lo,
    input  logic [2*CNT_W-1:0]                   func_code,
    output logic [2*CNT_W-1:0]                   dac_drive,
    output logic                                 done
);
    localparam int SEL_W  = $clog2(CNT_W);
    localparam int CFG_W  = CNT_W * SEL_W;
    localparam int CODE_W = 2 * CNT_W;

    logic             load;
    logic [CNT_W-1:0] cnt;
    seq_state_t       state;
    logic [CFG_W-1:0] cfg_hi_q;
    logic [CFG_W-1:0] cfg_lo_q;
    logic [CNT_W-1:0] code_hi;
    logic [CNT_W-1:0] code_lo;

    dts_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .start(start),
        .load(load), .cnt(cnt), .state(state), .done(done)
    );

    dts_shuffle #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_shuf_hi (
        .clk(clk), .rst_n(rst_n), .load(load), .cfg_in(shuf_hi),
        .cnt(cnt), .cfg_q(cfg_hi_q), .code(code_hi)
    );

    dts_shuffle #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_shuf_lo (
        .clk(clk), .rst_n(rst_n), .load(load), .cfg_in(shuf_lo),
        .cnt(cnt), .cfg_q(cfg_lo_q), .code(code_lo)
    );

    dts_bit_mux #(.W(CODE_W)) u_mux (
        .sel_test(test_en), .test_code({code_hi, code_lo}),
        .func_code(func_code), .dout(dac_drive)
    );
endmodule

// File: rtl/shuffled_dac_seq_checker.sv
module shuffled_dac_seq_checker
    import shuffled_dac_seq_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int CFG_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               test_en,
    input logic               start,
    input logic [2*CNT_W-1:0] func_code,
    input logic [2*CNT_W-1:0] dac_drive,
    input logic               done,
    input logic [CNT_W-1:0]   cnt,
    input seq_state_t         state,
    input logic [CFG_W-1:0]   cfg_hi_q,
    input logic [CFG_W-1:0]   cfg_lo_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && test_en && !start) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && start) |=> (cnt == '0 && state == SEQ_RUN));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == '0 && $past(cnt) == CNT_MAX && !$past(start)));

    assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> dac_drive == func_code);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (cnt == '0 && state == SEQ_IDLE));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_en && start) |=> ($stable(cfg_hi_q) && $stable(cfg_lo_q)));
endmodule

bind shuffled_dac_seq shuffled_dac_seq_checker #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .start(start),
    .func_code(func_code), .dac_drive(dac_drive), .done(done),
    .cnt(cnt), .state(state), .cfg_hi_q(cfg_hi_q), .cfg_lo_q(cfg_lo_q)
);

// File: tb/shuffled_dac_seq_test.sv
module shuffled_dac_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        test_en;
    logic        start;
    logic [14:0] shuf_hi;
    logic [14:0] shuf_lo;
    logic [9:0]  func_code;
    logic [9:0]  dac_drive;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    localparam logic [14:0] CFG_IDENT = {3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
    localparam logic [14:0] CFG_REV   = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4};
    localparam logic [14:0] CFG_ROT   = {3'd0, 3'd4, 3'd3, 3'd2, 3'd1};
    localparam logic [14:0] CFG_HIGH  = {5{3'd7}};
    localparam logic [14:0] CFG_MIX   = {3'd2, 3'd1, 3'd0, 3'd6, 3'd5};

    always #4 clk = ~clk;

    shuffled_dac_seq uut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .start(start),
        .shuf_hi(shuf_hi), .shuf_lo(shuf_lo), .func_code(func_code),
        .dac_drive(dac_drive), .done(done)
    );

    function automatic logic [4:0] perm(logic [14:0] cfg, logic [4:0] w);
        logic [4:0] r;
        for (int j = 0; j < 5; j++) begin
            logic [2:0] s;
            s = cfg[j*3 +: 3];
            if (s < 3'd5) r[j] = w[s];
            else          r[j] = w[0];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic launch();
        @(negedge clk);
        test_en = 1'b1;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    // Compares n consecutive samples starting from count k0; the first sample is taken now.
    task automatic follow(string tag, logic [14:0] hi, logic [14:0] lo, int k0, int n);
        for (int i = 0; i < n; i++) begin
            logic [4:0] w;
            w = 5'(k0 + i);
            check(tag, {22'd0, dac_drive}, {22'd0, perm(hi, w), perm(lo, w)});
            if (i != n - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R4 reset drive", {22'd0, dac_drive}, {22'd0, func_code});
        check("R3 reset done", {31'd0, done}, 32'd0);
    endtask

    task automatic t_bypass();
        logic [9:0] pats [3] = '{10'h3FF, 10'h000, 10'h155};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            func_code = pats[i];
            #1;
            check("R4 bypass", {22'd0, dac_drive}, {22'd0, pats[i]});
        end
        @(negedge clk);
        start = 1'b1;
        func_code = 10'h2A5;
        repeat (3) begin
            @(negedge clk);
            check("R5 start ignored drive", {22'd0, dac_drive}, {22'd0, 10'h2A5});
            check("R5 start ignored done", {31'd0, done}, 32'd0);
        end
        start = 1'b0;
    endtask

    task automatic t_hold_idle();
        @(negedge clk);
        shuf_hi = CFG_IDENT;
        shuf_lo = CFG_IDENT;
        test_en = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R5 hold zero", {22'd0, dac_drive}, 32'd0);
            check("R5 no done", {31'd0, done}, 32'd0);
        end
        test_en = 1'b0;
    endtask

    task automatic t_identity();
        shuf_hi = CFG_IDENT;
        shuf_lo = CFG_IDENT;
        func_code = 10'h3C3;
        launch();
        check("R3 no done at launch", {31'd0, done}, 32'd0);
        for (int k = 0; k < 32; k++) begin
            check("R1 count", {22'd0, dac_drive}, {22'd0, 5'(k), 5'(k)});
            if (k > 0) check("R3 done low mid-pass", {31'd0, done}, 32'd0);
            @(negedge clk);
        end
        check("R1 wrap to 0", {22'd0, dac_drive}, 32'd0);
        check("R3 done at wrap", {31'd0, done}, 32'd1);
        @(negedge clk);
        check("R1 second pass", {22'd0, dac_drive}, {22'd0, 5'd1, 5'd1});
        check("R3 done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_permute();
        shuf_hi = CFG_REV;
        shuf_lo = CFG_ROT;
        launch();
        follow("R6 reverse/rotate", CFG_REV, CFG_ROT, 0, 32);
        shuf_hi = CFG_HIGH;
        shuf_lo = CFG_MIX;
        launch();
        follow("R7 out-of-range fields", CFG_HIGH, CFG_MIX, 0, 32);
    endtask

    task automatic t_late_cfg();
        shuf_hi = CFG_IDENT;
        shuf_lo = CFG_IDENT;
        launch();
        follow("R8 before change", CFG_IDENT, CFG_IDENT, 0, 5);
        shuf_hi = CFG_REV;
        shuf_lo = CFG_MIX;
        @(negedge clk);
        follow("R8 old setting kept", CFG_IDENT, CFG_IDENT, 5, 10);
        launch();
        follow("R8 new setting after start", CFG_REV, CFG_MIX, 0, 6);
    endtask

    task automatic t_restart();
        shuf_hi = CFG_IDENT;
        shuf_lo = CFG_IDENT;
        launch();
        follow("R2 pre-restart", CFG_IDENT, CFG_IDENT, 0, 11);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 mid-pass restart", {22'd0, dac_drive}, 32'd0);
        @(negedge clk);
        follow("R2 after restart", CFG_IDENT, CFG_IDENT, 1, 31);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 restart at 31", {22'd0, dac_drive}, 32'd0);
        check("R3 no done on restart at 31", {31'd0, done}, 32'd0);
    endtask

    task automatic t_drop();
        shuf_hi = CFG_IDENT;
        shuf_lo = CFG_IDENT;
        func_code = 10'h19E;
        launch();
        follow("R1 pre-drop", CFG_IDENT, CFG_IDENT, 0, 7);
        test_en = 1'b0;
        #1;
        check("R4 immediate bypass", {22'd0, dac_drive}, {22'd0, 10'h19E});
        @(negedge clk);
        test_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R5 cleared after drop", {22'd0, dac_drive}, 32'd0);
        end
        test_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; test_en = 1'b0; start = 1'b0;
        shuf_hi = '0; shuf_lo = '0; func_code = 10'h2A5;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_bypass();
        t_hold_idle();
        t_identity();
        t_permute();
        t_late_cfg();
        t_restart();
        t_drop();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule